// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer that sits on a simple peripheral bus with APB-style select, enable, write, address and data signals. Software sets a reload value and a control word. The counter then steps down by one on each prescaled tick. When it expires it raises an interrupt flag. It can run in three modes. Free-running mode wraps over the whole 16-bit or 32-bit range. Periodic mode reloads from the programmed value. One-shot mode stops at zero and turns itself off.

Ticks come from a one-cycle strobe, `tick_en`, which stands in for the timer reference clock. A prescaler divides that strobe by 1, 16 or 256. A second write port for the reload value changes only the next reload and leaves the running count alone. The main load port reloads the counter at once. The interrupt output is a level. It stays high until software writes the clear register, and the interrupt-enable control bit masks it.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register reads 0x20 (only interrupt enable set), so the timer starts stopped in free-running, 16-bit, divide-by-1 mode. The current value, reload value and `irq` are all 0.
- R2: Registers are selected by `paddr[4:2]`: 0 load, 1 current value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. Reading index 0 or index 6 returns the reload value. A write to index 1 is ignored.
- R3: A write to index 0 sets the reload value and puts the written word into the counter on the same clock edge.
- R4: A write to index 6 sets the reload value only. The current count is unchanged until the next reload, and that reload uses the new value.
- R5: Periodic mode is control bit 6 = 1 with bit 0 = 0. Each tick lowers the count by one. The tick that takes the count from 1 to 0 is an expiry. The tick after that reloads from the reload value.
- R6: Free-running mode is control bits 6 and 0 both 0. The reload comes from 0xFFFF in 16-bit mode and from 0xFFFFFFFF in 32-bit mode (control bit 1 = 1), whatever the reload value is.
- R7: One-shot mode is control bit 0 = 1. At expiry the enable bit (bit 7) clears by itself. The count then stays at 0 until the load register is written.
- R8: In 16-bit mode only the low 16 bits of the count take part in counting and expiry, and the upper 16 bits of the current value read 0.
- R9: Control bits 3:2 select the tick divider: 01 gives one count per 16 `tick_en` pulses, 10 gives one per 256, and 00 or 11 gives one per pulse. Any control write restarts the divider from zero.
- R10: An expiry sets the raw flag, which reads as bit 0 of index 4. Any write to index 3 clears it. If an expiry and a clear land on the same cycle, the flag stays set.
- R11: `irq` is high exactly when the raw flag is set and control bit 5 is 1. Index 5 reads the raw flag ANDed with that bit.
- R12: The counter and divider move only while control bit 7 is set. `tick_en` pulses have no effect while the bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write access |
| paddr | input | ADDR_W | Byte address; bits 4:2 pick the register |
| pwdata | input | CNT_W | Write data |
| prdata | output | CNT_W | Read data for the addressed register |
| tick_en | input | 1 | One-cycle timer reference strobe |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The hardest case to reach is an expiry and an interrupt-clear write landing on the same clock edge. The bench loads a count of 1 and then raises `tick_en` in the same cycle as the clear write, so only the priority rule decides the outcome. Prescaler restarts are also hard to see from outside. The bench stops partway through a divide-by-16 run, rewrites the control word, and counts exactly fifteen more pulses, so a divider that was not restarted would already have stepped the counter.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic [2:0] {
      IDX_LOAD   = 3'd0,
      IDX_VALUE  = 3'd1,
      IDX_CTRL   = 3'd2,
      IDX_ICLR   = 3'd3,
      IDX_RIS    = 3'd4,
      IDX_MIS    = 3'd5,
      IDX_BGLOAD = 3'd6
   } reg_idx_e;

   typedef enum logic [1:0] {
      PRE_DIV1  = 2'b00,
      PRE_DIV_A = 2'b01,
      PRE_DIV_B = 2'b10,
      PRE_RSVD  = 2'b11
   } pre_sel_e;

   typedef struct packed {
      logic     en;        // bit 7
      logic     periodic;  // bit 6
      logic     ie;        // bit 5
      logic     rsv;       // bit 4
      pre_sel_e pre;       // bits 3:2
      logic     wide;      // bit 1
      logic     oneshot;   // bit 0
   } ctrl_t;

   localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
   import cdt_pkg::*;
#(
   parameter int PRE_W     = 8,
   parameter int DIV_A_LOG = 4,
   parameter int DIV_B_LOG = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     tick_en,
   input  logic     restart,
   input  pre_sel_e pre,
   output logic     tick_o
);
   localparam logic [PRE_W-1:0] LIM_A = PRE_W'((1 << DIV_A_LOG) - 1);
   localparam logic [PRE_W-1:0] LIM_B = PRE_W'((1 << DIV_B_LOG) - 1);

   if (DIV_A_LOG > PRE_W || DIV_B_LOG > PRE_W || DIV_A_LOG < 1) begin : g_bad_div
      $error("cdt_prescale: divider exponents must lie in 1..PRE_W");
   end

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] lim;
   logic             hit;

   always_comb begin
      case (pre)
         PRE_DIV_A: lim = LIM_A;
         PRE_DIV_B: lim = LIM_B;
         default:   lim = '0;
      endcase
   end

   assign hit    = (pcnt >= lim);
   assign tick_o = run & tick_en & hit & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (restart)          pcnt <= '0;
      else if (run && tick_en)   pcnt <= hit ? '0 : pcnt + 1'b1;
   end

   AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0)); // R9

   AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(pcnt)); // R12

endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wide,
   input  logic             oneshot,
   input  logic             periodic,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_data,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] value_o,
   output logic             expire_o
);
   localparam int HALF_W = CNT_W / 2;
   localparam logic [CNT_W-1:0] HALF_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] reload_src;

   assign mask       = wide ? '1 : HALF_MASK;
   assign cur        = cnt & mask;
   assign reload_src = (oneshot || periodic) ? (reload_val & mask) : mask;
   assign expire_o   = tick & ~load_wr & (cur == CNT_W'(1));
   assign value_o    = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_wr) begin
         cnt <= load_data;
      end else if (tick) begin
         if (cur == '0) begin
            if (!oneshot) cnt <= reload_src;
         end else begin
            cnt <= (cnt - 1'b1) & mask;
         end
      end
   end

   AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (cnt == $past(load_data))); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_wr) |=> $stable(cnt)); // R4

   AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_wr && oneshot && (cur == '0)) |=> (value_o == '0)); // R7

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int CNT_W     = 32,
   parameter int PRE_W     = 8,
   parameter int DIV_A_LOG = 4,
   parameter int DIV_B_LOG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [CNT_W-1:0]  pwdata,
   output logic [CNT_W-1:0]  prdata,
   input  logic              tick_en,
   output logic              irq
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("cdt_timer: ADDR_W must be at least 5");
   end
   if (CNT_W < 16 || (CNT_W % 2) != 0) begin : g_bad_cnt
      $error("cdt_timer: CNT_W must be even and at least 16");
   end

   reg_idx_e         idx;
   logic             wr, wr_load, wr_ctrl, wr_clr, wr_bg;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic             raw_q;
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] value;

   assign idx     = reg_idx_e'(paddr[4:2]);
   assign wr      = psel & penable & pwrite;
   assign wr_load = wr & (idx == IDX_LOAD);
   assign wr_ctrl = wr & (idx == IDX_CTRL);
   assign wr_clr  = wr & (idx == IDX_ICLR);
   assign wr_bg   = wr & (idx == IDX_BGLOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_t'(CTRL_RESET);
      end else if (wr_ctrl) begin
         ctrl_q     <= ctrl_t'(pwdata[7:0]);
         ctrl_q.rsv <= 1'b0;
      end else if (expire && ctrl_q.oneshot) begin
         ctrl_q.en <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 reload_q <= '0;
      else if (wr_load || wr_bg)  reload_q <= pwdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw_q <= 1'b0;
      else if (expire)  raw_q <= 1'b1;
      else if (wr_clr)  raw_q <= 1'b0;
   end

   cdt_prescale #(
      .PRE_W(PRE_W), .DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .tick_en(tick_en),
      .restart(wr_ctrl), .pre(ctrl_q.pre), .tick_o(tick)
   );

   cdt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wide(ctrl_q.wide),
      .oneshot(ctrl_q.oneshot), .periodic(ctrl_q.periodic),
      .load_wr(wr_load), .load_data(pwdata), .reload_val(reload_q),
      .value_o(value), .expire_o(expire)
   );

   assign irq = raw_q & ctrl_q.ie;

   always_comb begin
      case (idx)
         IDX_LOAD, IDX_BGLOAD: prdata = reload_q;
         IDX_VALUE:            prdata = value;
         IDX_CTRL:             prdata = CNT_W'(ctrl_q);
         IDX_RIS:              prdata = CNT_W'(raw_q);
         IDX_MIS:              prdata = CNT_W'(raw_q & ctrl_q.ie);
         default:              prdata = '0;
      endcase
   end

   AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && expire) |=> raw_q); // R10

   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !expire) |=> !raw_q); // R10

   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.en); // R7

   AST_EXPIRE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> ctrl_q.en); // R12

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [4:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        tick_en = 1'b0;
   logic        irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   logic  mon_req = 1'b0;

   always #5 clk = ~clk;

   cdt_timer u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick_en(tick_en), .irq(irq)
   );

   // monitor: compares each queued expectation at the falling edge
   always @(negedge clk) begin
      if (mon_req && exp_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = exp_q.pop_front();
         act = it.is_irq ? {31'b0, irq} : prdata;
         compared++;
         if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input int idx, input logic [31:0] d);
      @(posedge clk); #1;
      psel = 1; penable = 1; pwrite = 1; paddr = 5'(idx << 2); pwdata = d;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic chk(input int idx, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      psel = 1; penable = 1; pwrite = 0; paddr = 5'(idx << 2);
      it.is_irq = 0; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      mon_req = 1;
      @(posedge clk); #1;
      mon_req = 0; psel = 0; penable = 0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
      exp_q.push_back(it);
      mon_req = 1;
      @(posedge clk); #1;
      mon_req = 0;
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1;
      tick_en = 1;
      repeat (n) @(posedge clk);
      #1 tick_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk(2, 32'h20, "R1 ctrl reset");
      chk(1, 32'h0, "R1 value reset");
      chk(0, 32'h0, "R1 load reset");
      chk_irq(0, "R1 irq reset");
      // R3 / R2 load and readback
      wr(0, 10);
      chk(1, 10, "R3 load sets count");
      chk(0, 10, "R2 load readback");
      chk(6, 10, "R2 bgload readback");
      wr(1, 32'h55);
      chk(1, 10, "R2 value write ignored");
      // R5 periodic
      wr(2, 32'hE0);
      ticks(3);
      chk(1, 7, "R5 count down");
      ticks(7);
      chk(1, 0, "R5 reach zero");
      chk(4, 1, "R10 raw set on expiry");
      chk_irq(1, "R11 irq asserted");
      ticks(1);
      chk(1, 10, "R5 reload");
      // R4 background load
      wr(6, 4);
      chk(1, 10, "R4 bgload keeps count");
      chk(0, 4, "R2 load reads bg value");
      ticks(10);
      chk(1, 0, "R4 count to zero");
      ticks(1);
      chk(1, 4, "R4 reload from bg value");
      // R10 / R11 clear and mask
      wr(3, 0);
      chk(4, 0, "R10 clear");
      chk_irq(0, "R10 irq low after clear");
      wr(2, 32'hC0);
      ticks(4);
      chk(4, 1, "R11 raw set with ie off");
      chk(5, 0, "R11 masked reads zero");
      chk_irq(0, "R11 irq gated");
      wr(3, 0);
      // R10 expiry beats clear on the same cycle
      wr(0, 1);
      @(posedge clk); #1;
      psel = 1; penable = 1; pwrite = 1; paddr = 5'(3 << 2); tick_en = 1;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0; tick_en = 0;
      chk(4, 1, "R10 expiry wins over clear");
      wr(3, 0);
      // R12 disabled
      wr(2, 32'h40);
      wr(0, 5);
      ticks(3);
      chk(1, 5, "R12 no count when disabled");
      // R6 free-running
      wr(2, 32'hA0);
      wr(0, 2);
      ticks(2);
      chk(1, 0, "R6 free 16 zero");
      ticks(1);
      chk(1, 32'hFFFF, "R6 free 16 wrap");
      ticks(1);
      chk(1, 32'hFFFE, "R6 free 16 continue");
      wr(2, 32'hA2);
      wr(0, 1);
      ticks(2);
      chk(1, 32'hFFFF_FFFF, "R6 free 32 wrap");
      // R8 16-bit view
      wr(2, 32'h40);
      wr(0, 32'h12345);
      chk(1, 32'h2345, "R8 upper bits zero");
      chk(0, 32'h12345, "R8 load keeps full word");
      wr(2, 32'hE0);
      ticks(1);
      chk(1, 32'h2344, "R8 low half counts");
      wr(3, 0);
      wr(0, 32'h10001);
      ticks(1);
      chk(4, 1, "R8 expiry on low half");
      wr(3, 0);
      // R7 one-shot
      wr(2, 32'hA1);
      wr(0, 3);
      ticks(3);
      chk(1, 0, "R7 one-shot zero");
      chk(4, 1, "R7 one-shot expiry flag");
      chk(2, 32'h21, "R7 enable cleared");
      ticks(2);
      chk(1, 0, "R7 holds at zero");
      wr(2, 32'hA1);
      ticks(2);
      chk(1, 0, "R7 no reload without load");
      wr(3, 0);
      // R9 prescaler
      wr(2, 32'hC4);
      wr(0, 100);
      ticks(15);
      chk(1, 100, "R9 div16 before 16th pulse");
      ticks(1);
      chk(1, 99, "R9 div16 step");
      wr(2, 32'hC8);
      ticks(255);
      chk(1, 99, "R9 div256 before 256th pulse");
      ticks(1);
      chk(1, 98, "R9 div256 step");
      wr(2, 32'hC4);
      ticks(10);
      wr(2, 32'hC4);
      ticks(15);
      chk(1, 98, "R9 restart on ctrl write");
      ticks(1);
      chk(1, 97, "R9 step after restart");
      wr(2, 32'hCC);
      ticks(1);
      chk(1, 96, "R9 code 11 divides by one");
      repeat (3) @(posedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule